// File: doc/BRIEF.md
# Shadow branch cache-line scanner

The scanner accepts one instruction cache line that the fetch-directed prefetcher has already brought in. With it comes the window that ordinary decode consumed. That window opens at the entry slot, where the previous taken branch landed. It closes at the exit slot, which holds the taken branch that leaves the line. Decode never looks at the slots outside this window. The scanner examines those skipped head and tail slots and reports each branch instruction it finds there, so that a side buffer beside the branch target buffer can learn branches that were never decoded.

Instructions use a fixed 4-byte, 4-byte-aligned encoding. A 64-byte line therefore holds 16 slots, and slot 0 sits in the least significant 32 bits of the line. The top two bits of a word mark it as a branch. The next two bits give its kind. The remaining 28 bits are a signed byte displacement. Found branches leave the block one per cycle on a valid/ready channel. No new line is taken until every branch of the current one has been handed over.

Top module: `sbs_scanner`

## Requirements
- R1: After reset `busy` and `br_valid` are 0 and `line_ready` is 1. A line is taken on a rising edge where `line_valid` and `line_ready` are both 1. A reset during a scan drops all pending results.
- R2: A word is a branch when bits [31:30] are 2'b11. Bits [29:28] give `br_type`: 0 conditional, 1 jump, 2 call, 3 indirect. Any other word is never reported.
- R3: With `exit_taken` = 1, only branches in slots below `entry_slot` or above `exit_slot` are reported. Every such branch is reported exactly once, and none from the window between.
- R4: With `exit_taken` = 0, only the head region (slots below `entry_slot`) is scanned.
- R5: Branches are reported in ascending slot order, which puts the head region first. While `br_valid` is 1 and `br_ready` is 0, every branch output holds its value.
- R6: `br_addr` equals `line_addr` with its low 6 bits cleared, plus 4 times the slot index.
- R7: For a direct branch, `br_target` = `br_addr` + the sign-extended 28-bit displacement in bits [27:0], and `br_has_target` is 1. For an indirect branch, `br_has_target` is 0 and `br_target` is 0.
- R8: `busy` stays 1 and `line_ready` stays 0 until the last branch of the line is accepted. A line offered meanwhile is ignored.
- R9: A line with no branch outside the window leaves `busy` and `br_valid` at 0 and is ready for the next line in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_valid | input | 1 | A line is offered |
| line_ready | output | 1 | Scanner can take a line |
| line_addr | input | 32 | Address of the line (low bits ignored) |
| line_data | input | 512 | Line contents, slot 0 in bits [31:0] |
| entry_slot | input | 4 | First slot consumed by normal decode |
| exit_slot | input | 4 | Slot of the taken branch leaving the line |
| exit_taken | input | 1 | The line has a taken exit branch |
| busy | output | 1 | Results of the current line are pending |
| br_valid | output | 1 | A shadow branch is presented |
| br_ready | input | 1 | Consumer takes the presented branch |
| br_addr | output | 32 | Byte address of the branch |
| br_type | output | 2 | Branch kind |
| br_target | output | 32 | Direct target, 0 for indirect |
| br_has_target | output | 1 | `br_target` is meaningful |

## Verification
The bench aims at the window edges: entry at slot 0, exit at slot 15, entry and exit on the same slot, and a line without a taken exit. A design with an off-by-one compare would report the entry or exit branch itself, or it would drop the slot just beside the window. A design that scanned the tail without a taken exit would report branches past the nominal exit. Back-pressure every other cycle exposes a design that skips or repeats a branch when a transfer stalls. Offering a second line while busy exposes a design that overwrites its pending state mid-scan. A line address with low bits set and negative displacements expose wrong base masking and wrong sign extension.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

   typedef enum logic [1:0] {
      BR_COND = 2'd0,
      BR_JUMP = 2'd1,
      BR_CALL = 2'd2,
      BR_IND  = 2'd3
   } br_kind_e;

   localparam logic [1:0] BRANCH_CLASS = 2'b11;

   function automatic logic is_branch_class(input logic [1:0] cls);
      return cls == BRANCH_CLASS;
   endfunction

endpackage

// File: rtl/sbs_slot_decode.sv
module sbs_slot_decode
   import sbs_pkg::*;
#(
   parameter int INSN_W = 32,
   parameter int ADDR_W = 32
) (
   input  logic [INSN_W-1:0] word,
   input  logic [ADDR_W-1:0] pc,
   output logic              is_br,
   output br_kind_e          kind,
   output logic [ADDR_W-1:0] target,
   output logic              has_target
);
   localparam int IMM_W = INSN_W - 4;

   generate
      if (ADDR_W <= IMM_W) begin : g_bad_width
         $error("sbs_slot_decode: ADDR_W must exceed the displacement width");
      end
   endgenerate

   logic [IMM_W-1:0]  disp;
   logic [ADDR_W-1:0] disp_ext;

   always_comb begin
      is_br      = is_branch_class(word[INSN_W-1 -: 2]);
      kind       = br_kind_e'(word[INSN_W-3 -: 2]);
      disp       = word[IMM_W-1:0];
      disp_ext   = {{(ADDR_W-IMM_W){disp[IMM_W-1]}}, disp};
      has_target = is_br && (kind != BR_IND);
      target     = has_target ? (pc + disp_ext) : '0;
   end
endmodule

// File: rtl/sbs_window_mask.sv
module sbs_window_mask #(
   parameter int SLOTS  = 16,
   parameter int SLOT_W = 4
) (
   input  logic [SLOT_W-1:0] entry_slot,
   input  logic [SLOT_W-1:0] exit_slot,
   input  logic              exit_taken,
   output logic [SLOTS-1:0]  shadow
);
   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_slot
         localparam logic [SLOT_W-1:0] IDX = SLOT_W'(s);
         logic in_head, in_tail;
         assign in_head   = IDX < entry_slot;
         assign in_tail   = exit_taken && (IDX > exit_slot);
         assign shadow[s] = in_head || in_tail;
      end
   endgenerate
endmodule

// File: rtl/sbs_lowest_pick.sv
module sbs_lowest_pick #(
   parameter int SLOTS  = 16,
   parameter int SLOT_W = 4
) (
   input  logic [SLOTS-1:0]  req,
   output logic              any,
   output logic [SLOT_W-1:0] idx,
   output logic [SLOTS-1:0]  onehot
);
   always_comb begin
      idx    = '0;
      onehot = '0;
      for (int s = SLOTS - 1; s >= 0; s--) begin
         if (req[s]) begin
            idx    = SLOT_W'(s);
            onehot = SLOTS'(1) << s;
         end
      end
      any = |req;
   end
endmodule

// File: rtl/sbs_scanner.sv
module sbs_scanner
   import sbs_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int LINE_BYTES = 64,
   parameter int INSN_BYTES = 4
) (
   input  logic                                 clk,
   input  logic                                 rst_n,
   input  logic                                 line_valid,
   output logic                                 line_ready,
   input  logic [ADDR_W-1:0]                    line_addr,
   input  logic [LINE_BYTES*8-1:0]              line_data,
   input  logic [$clog2(LINE_BYTES/INSN_BYTES)-1:0] entry_slot,
   input  logic [$clog2(LINE_BYTES/INSN_BYTES)-1:0] exit_slot,
   input  logic                                 exit_taken,
   output logic                                 busy,
   output logic                                 br_valid,
   input  logic                                 br_ready,
   output logic [ADDR_W-1:0]                    br_addr,
   output logic [1:0]                           br_type,
   output logic [ADDR_W-1:0]                    br_target,
   output logic                                 br_has_target
);
   localparam int SLOTS   = LINE_BYTES / INSN_BYTES;
   localparam int SLOT_W  = $clog2(SLOTS);
   localparam int INSN_W  = INSN_BYTES * 8;
   localparam int LINE_W  = LINE_BYTES * 8;
   localparam int INSN_SH = $clog2(INSN_BYTES);
   localparam int OFF_W   = $clog2(LINE_BYTES);

   generate
      if (LINE_BYTES % INSN_BYTES != 0) begin : g_bad_line
         $error("sbs_scanner: line size must be a multiple of the instruction size");
      end
      if ((1 << OFF_W) != LINE_BYTES) begin : g_bad_pow2
         $error("sbs_scanner: line size must be a power of two");
      end
      if (INSN_BYTES < 2) begin : g_bad_insn
         $error("sbs_scanner: instruction too narrow for the opcode field");
      end
   endgenerate

   // decode branch class of every incoming slot
   logic [SLOTS-1:0] is_br_in;
   generate
      for (genvar s = 0; s < SLOTS; s++) begin : g_cls
         assign is_br_in[s] = is_branch_class(line_data[s*INSN_W + INSN_W - 1 -: 2]);
      end
   endgenerate

   logic [SLOTS-1:0] shadow;
   sbs_window_mask #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_window (
      .entry_slot (entry_slot),
      .exit_slot  (exit_slot),
      .exit_taken (exit_taken),
      .shadow     (shadow)
   );

   logic [LINE_W-1:0] line_q;
   logic [ADDR_W-1:0] base_q;
   logic [SLOTS-1:0]  pending_q;
   logic [SLOT_W-1:0] entry_q, exit_q;
   logic              taken_q;

   logic              any_pending;
   logic [SLOT_W-1:0] pick_idx;
   logic [SLOTS-1:0]  pick_onehot;

   sbs_lowest_pick #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_pick (
      .req    (pending_q),
      .any    (any_pending),
      .idx    (pick_idx),
      .onehot (pick_onehot)
   );

   logic accept, handoff;
   assign busy       = any_pending;
   assign line_ready = !any_pending;
   assign br_valid   = any_pending;
   assign accept     = line_valid && line_ready;
   assign handoff    = br_valid && br_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_q    <= '0;
         base_q    <= '0;
         pending_q <= '0;
         entry_q   <= '0;
         exit_q    <= '0;
         taken_q   <= 1'b0;
      end else if (accept) begin
         line_q    <= line_data;
         base_q    <= line_addr & ~ADDR_W'(LINE_BYTES - 1);
         pending_q <= is_br_in & shadow;
         entry_q   <= entry_slot;
         exit_q    <= exit_slot;
         taken_q   <= exit_taken;
      end else if (handoff) begin
         pending_q <= pending_q & ~pick_onehot;
      end
   end

   logic [INSN_W-1:0] sel_word;
   logic [ADDR_W-1:0] sel_pc;
   logic              sel_is_br;
   br_kind_e          sel_kind;

   assign sel_word = line_q[pick_idx*INSN_W +: INSN_W];
   assign sel_pc   = base_q + (ADDR_W'(pick_idx) << INSN_SH);

   sbs_slot_decode #(.INSN_W(INSN_W), .ADDR_W(ADDR_W)) u_dec (
      .word       (sel_word),
      .pc         (sel_pc),
      .is_br      (sel_is_br),
      .kind       (sel_kind),
      .target     (br_target),
      .has_target (br_has_target)
   );

   assign br_addr = sel_pc;
   assign br_type = sel_kind;

   logic [SLOT_W-1:0] out_slot;
   assign out_slot = br_addr[INSN_SH +: SLOT_W];

   // R1
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !br_valid);

   // R2
   only_branch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      br_valid |-> sel_is_br);

   // R3
   outside_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      br_valid |-> ((out_slot < entry_q) || (taken_q && out_slot > exit_q)));

   // R5
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && !br_ready) |=> (br_valid && $stable(br_addr) && $stable(br_type)
                                   && $stable(br_target)));

   // R5
   ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && br_ready) |=> (!br_valid || (br_addr > $past(br_addr))));

   // R7
   indirect_notgt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (br_valid && br_type == 2'd3) |-> (!br_has_target && br_target == '0));

   // R8
   hold_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !(br_valid && br_ready)) |=> busy);
endmodule

// File: tb/sbs_scanner_test.sv
module sbs_scanner_test;
   localparam int CLK_PERIOD = 10;

   typedef struct packed {
      logic [15:0] brs;
      logic [3:0]  ent;
      logic [3:0]  ext;
      logic        tk;
      logic [15:0] exp;
      logic [31:0] addr;
   } vec_t;

   localparam int NV = 7;
   localparam vec_t VECS [NV] = '{
      '{16'hFFFF, 4'd4,  4'd10, 1'b1, 16'hF80F, 32'h0001_0000},
      '{16'hFFFF, 4'd4,  4'd10, 1'b0, 16'h000F, 32'h0001_0040},
      '{16'h0000, 4'd0,  4'd15, 1'b1, 16'h0000, 32'h0001_0080},
      '{16'hA5A5, 4'd0,  4'd15, 1'b1, 16'h0000, 32'h0001_00C0},
      '{16'hA5A5, 4'd6,  4'd9,  1'b1, 16'hA425, 32'h0001_0100},
      '{16'h8001, 4'd15, 4'd15, 1'b0, 16'h0001, 32'h0002_0013},
      '{16'h8001, 4'd0,  4'd0,  1'b1, 16'h8000, 32'h0003_007F}
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         line_valid = 1'b0;
   logic         line_ready;
   logic [31:0]  line_addr = '0;
   logic [511:0] line_data = '0;
   logic [3:0]   entry_slot = '0;
   logic [3:0]   exit_slot = '0;
   logic         exit_taken = 1'b0;
   logic         busy, br_valid, br_has_target;
   logic         br_ready = 1'b0;
   logic [31:0]  br_addr, br_target;
   logic [1:0]   br_type;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sbs_scanner uut (
      .clk(clk), .rst_n(rst_n), .line_valid(line_valid), .line_ready(line_ready),
      .line_addr(line_addr), .line_data(line_data), .entry_slot(entry_slot),
      .exit_slot(exit_slot), .exit_taken(exit_taken), .busy(busy),
      .br_valid(br_valid), .br_ready(br_ready), .br_addr(br_addr),
      .br_type(br_type), .br_target(br_target), .br_has_target(br_has_target)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] disp_of(input int s);
      return (s % 2 == 0) ? (32'h0000_0100 + 32'(s)) : 32'hFFFF_FF00;
   endfunction

   function automatic logic [511:0] build_line(input logic [15:0] brs);
      logic [511:0] l = '0;
      for (int s = 0; s < 16; s++) begin
         if (brs[s]) l[s*32 +: 32] = {2'b11, 2'(s), disp_of(s)[27:0]};
         else        l[s*32 +: 32] = 32'h1234_0000 | 32'(s);
      end
      return l;
   endfunction

   task automatic run_vec(input vec_t v, input bit stall, input bit noise, input string tag);
      logic [15:0] left = v.exp;
      logic [31:0] base = v.addr & 32'hFFFF_FFC0;
      logic [31:0] held = '0;
      bit prev_stall = 0;
      int cyc = 0;
      @(negedge clk);
      chk(line_ready, "R1 ready before offer", 32'(line_ready), 1);
      line_addr = v.addr; line_data = build_line(v.brs);
      entry_slot = v.ent; exit_slot = v.ext; exit_taken = v.tk; line_valid = 1'b1;
      @(negedge clk);
      if (noise) begin
         line_data = build_line(16'hFFFF); entry_slot = 4'd15; exit_slot = 4'd0;
         exit_taken = 1'b1; line_addr = 32'h0F00_0000;
      end else line_valid = 1'b0;
      while (busy && cyc < 200) begin
         if (noise) chk(!line_ready, "R8 not ready while busy", 32'(line_ready), 0);
         br_ready = stall ? (cyc % 2 == 1) : 1'b1;
         if (prev_stall) chk(br_addr == held, "R5 hold under stall", br_addr, held);
         if (br_valid) begin
            int s = -1;
            for (int k = 15; k >= 0; k--) if (left[k]) s = k;
            if (s < 0) chk(0, {tag, " extra branch"}, br_addr, 0);
            else begin
               logic [31:0] a = base + 32'(s) * 4;
               logic [31:0] t = (s % 4 == 3) ? 32'h0 : a + disp_of(s);
               chk(br_addr == a, "R6 R5 address order", br_addr, a);
               chk(br_type == 2'(s), "R2 type", 32'(br_type), 32'(s % 4));
               chk(br_target == t && br_has_target == (s % 4 != 3), "R7 target",
                   br_target, t);
               if (br_ready) left[s] = 1'b0;
            end
         end
         held = br_addr;
         prev_stall = !br_ready;
         cyc++;
         @(negedge clk);
      end
      line_valid = 1'b0;
      br_ready = 1'b0;
      chk(left == 16'h0, {tag, " all shadow branches reported"}, 32'(left), 0);
      chk(!br_valid && line_ready, {tag, " idle after line"}, 32'(br_valid), 0);
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual hung expected finish");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (2) @(negedge clk);
      chk(!busy, "R1 reset busy", 32'(busy), 0);
      chk(!br_valid, "R1 reset valid", 32'(br_valid), 0);
      chk(line_ready, "R1 reset ready", 32'(line_ready), 1);
      rst_n = 1'b1;
      for (int i = 0; i < NV; i++) begin
         string tag;
         if (!VECS[i].tk)           tag = "R4";
         else if (VECS[i].exp == 0) tag = "R9 R3";
         else                       tag = "R3";
         run_vec(VECS[i], (i % 2 == 1), 1'b0, tag);
      end
      // R5: stalled drain of the two-region line
      run_vec(VECS[0], 1'b1, 1'b0, "R5 R3");
      // R8: a second line offered during a scan is ignored
      run_vec(VECS[4], 1'b1, 1'b1, "R8");
      // R1: reset in the middle of a scan
      @(negedge clk);
      line_addr = VECS[0].addr; line_data = build_line(VECS[0].brs);
      entry_slot = VECS[0].ent; exit_slot = VECS[0].ext; exit_taken = 1'b1;
      line_valid = 1'b1;
      @(negedge clk);
      line_valid = 1'b0;
      chk(br_valid, "R1 scan started", 32'(br_valid), 1);
      rst_n = 1'b0;
      #1;
      chk(!br_valid && !busy, "R1 reset drops scan", 32'(br_valid), 0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(line_ready && !br_valid, "R1 ready after reset", 32'(line_ready), 1);
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule